// File: doc/BRIEF.md
# ISR Cycle Profiler and Counter Overrun Monitor

This block sits beside a small microcontroller core and watches the strobes the core raises when it takes an interrupt and when it returns from one. It also watches the core's per-instruction-cycle tick. For every interrupt service routine it measures the number of ticks spent inside it. It keeps the shortest and the longest duration seen, a running sum of all durations and the number of completed routines. From these it derives the mean duration with a small serial divider, so the mean is the true average over all calls and not a midpoint between the extremes.

The block also models the core's 8-bit real-time counter. The counter advances on its own tick. When the routine ends with the return-and-add-W form, the counter instead takes the sum of its value and the W operand, modulo 256. If the counter wraps while a routine is in progress and the check is enabled, a sticky flag rises on the same clock edge as the wrap. The flag does not wait for the return. Software reads the statistics and the flag, and writes the clear input to reset the flag.

Top module: `isr_profiler`

## Requirements
- R1: After reset the minimum reads all ones, the maximum, total and count read zero, the counter reads zero, the overrun flag is low and avg_valid is low.
- R2: A routine's duration is the number of cycles with cycle_tick high, from the cycle in which isr_enter is accepted up to and including the cycle of isr_return. The duration saturates at 2^CYC_W-1.
- R3: An isr_enter seen while a routine is already in progress has no effect on the measurement. An isr_return seen while no routine is in progress is ignored and leaves every statistic unchanged.
- R4: On each accepted return, the minimum and maximum take the new duration if it is smaller or larger, respectively. The maximum never decreases and the minimum never increases.
- R5: The total (TOTAL_W bits) adds each duration and the count (COUNT_W bits) adds one per return. Both saturate at all ones and never wrap.
- R6: avg_cycles equals floor(total/count). avg_valid falls two clock edges after the return cycle, together with the statistics update. It rises again at most TOTAL_W+2 cycles later.
- R7: rtcc_value is RTCC_W (8) bits wide. It increments on each rtcc_tick and wraps from 255 to 0.
- R8: On an accepted return with retiw high, rtcc_value becomes (rtcc_value + w_value) mod 256. Any rtcc_tick in that cycle is then ignored.
- R9: overrun sets on the same edge at which the counter wraps, by tick or by the retiw add. This happens only when a routine is in progress (from the cycle after entry through the return cycle) and ovf_chk_en is high. A wrap outside a routine, or with the check disabled, leaves overrun unchanged.
- R10: overrun stays high until ovf_clear is asserted. A set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| isr_enter | input | 1 | Core takes an interrupt this cycle |
| isr_return | input | 1 | Core returns from the routine this cycle |
| retiw | input | 1 | The return is the add-W variant |
| w_value | input | RTCC_W | W operand for the add-W return |
| cycle_tick | input | 1 | One instruction cycle elapsed |
| rtcc_tick | input | 1 | Real-time counter increment |
| ovf_chk_en | input | 1 | Enables the in-routine wrap check |
| ovf_clear | input | 1 | Clears the overrun flag |
| cyc_min | output | CYC_W | Shortest duration seen |
| cyc_max | output | CYC_W | Longest duration seen |
| cyc_total | output | TOTAL_W | Saturating sum of durations |
| isr_count | output | COUNT_W | Saturating number of routines |
| avg_cycles | output | TOTAL_W | Mean duration |
| avg_valid | output | 1 | avg_cycles is up to date |
| rtcc_value | output | RTCC_W | Modelled real-time counter |
| overrun | output | 1 | Sticky wrap-inside-routine flag |

## Verification
The bench is built with narrow widths so that duration, total and count all reach saturation. A design that wraps would show a small total or a count near zero. A second isr_enter in the middle of a routine must not restart the measurement, or the duration would come out short. A stray return must not add a call. A one-tick wrap is watched cycle by cycle inside a routine: the flag must be low at 255 and high at 0 before the return is issued. A late design would only raise it at the return. The add-W return is driven together with a counter tick, and the flag is driven together with a clear. These expose a design that applies both counter updates or lets the clear win. Wraps outside a routine and wraps with the check disabled must leave the flag low.

// File: rtl/isrprof_pkg.sv
`timescale 1ns/1ps
package isrprof_pkg;

   typedef enum logic [1:0] {
      DV_IDLE = 2'd0,
      DV_LOAD = 2'd1,
      DV_RUN  = 2'd2
   } dv_state_e;

endpackage

// File: rtl/isr_span_meter.sv
`timescale 1ns/1ps
module isr_span_meter #(
   parameter int CYC_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             isr_enter,
   input  logic             isr_return,
   input  logic             cycle_tick,
   output logic             in_isr,
   output logic             ret_take,
   output logic             done,
   output logic [CYC_W-1:0] dur
);
   localparam logic [CYC_W-1:0] CYC_MAX = '1;

   logic             active;
   logic [CYC_W-1:0] cur;
   logic [CYC_W-1:0] cur_inc;

   assign cur_inc  = (cycle_tick && (cur != CYC_MAX)) ? cur + CYC_W'(1) : cur;
   assign in_isr   = active;
   assign ret_take = active & isr_return;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         cur    <= '0;
         done   <= 1'b0;
         dur    <= '0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (isr_enter) begin
               active <= 1'b1;
               cur    <= CYC_W'(cycle_tick);
            end
         end else if (isr_return) begin
            active <= 1'b0;
            done   <= 1'b1;
            dur    <= cur_inc;
         end else begin
            cur <= cur_inc;
         end
      end
   end
endmodule

// File: rtl/isr_stat_accum.sv
`timescale 1ns/1ps
module isr_stat_accum #(
   parameter int CYC_W   = 16,
   parameter int TOTAL_W = 32,
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               done,
   input  logic [CYC_W-1:0]   dur,
   output logic [CYC_W-1:0]   min_q,
   output logic [CYC_W-1:0]   max_q,
   output logic [TOTAL_W-1:0] tot_q,
   output logic [COUNT_W-1:0] cnt_q
);
   localparam logic [COUNT_W-1:0] CNT_MAX = '1;
   localparam logic [TOTAL_W-1:0] TOT_MAX = '1;

   logic [TOTAL_W:0]   tot_sum;
   logic [TOTAL_W-1:0] tot_next;

   assign tot_sum  = {1'b0, tot_q} + (TOTAL_W+1)'(dur);
   assign tot_next = tot_sum[TOTAL_W] ? TOT_MAX : tot_sum[TOTAL_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         min_q <= '1;
         max_q <= '0;
         tot_q <= '0;
         cnt_q <= '0;
      end else if (done) begin
         if (dur < min_q) min_q <= dur;
         if (dur > max_q) max_q <= dur;
         tot_q <= tot_next;
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + COUNT_W'(1);
      end
   end
endmodule

// File: rtl/isr_avg_div.sv
`timescale 1ns/1ps
module isr_avg_div
   import isrprof_pkg::*;
#(
   parameter int TOTAL_W = 32,
   parameter int COUNT_W = 16
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               start,
   input  logic [TOTAL_W-1:0] dividend,
   input  logic [COUNT_W-1:0] divisor,
   output logic [TOTAL_W-1:0] quotient,
   output logic               valid
);
   localparam int STEP_W = $clog2(TOTAL_W + 1);

   dv_state_e          state;
   logic [TOTAL_W-1:0] dvd;
   logic [COUNT_W-1:0] dsr;
   logic [COUNT_W-1:0] rem;
   logic [STEP_W-1:0]  step;
   logic [COUNT_W:0]   trial;
   logic [COUNT_W:0]   diff;
   logic               ge;
   logic [TOTAL_W-1:0] dvd_next;

   assign trial    = {rem, dvd[TOTAL_W-1]};
   assign ge       = trial >= {1'b0, dsr};
   assign diff     = trial - {1'b0, dsr};
   assign dvd_next = {dvd[TOTAL_W-2:0], ge};

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= DV_IDLE;
         dvd      <= '0;
         dsr      <= '0;
         rem      <= '0;
         step     <= '0;
         quotient <= '0;
         valid    <= 1'b0;
      end else if (start) begin
         state <= DV_LOAD;
         valid <= 1'b0;
      end else begin
         case (state)
            DV_LOAD: begin
               dvd   <= dividend;
               dsr   <= divisor;
               rem   <= '0;
               step  <= '0;
               state <= DV_RUN;
            end
            DV_RUN: begin
               dvd <= dvd_next;
               rem <= ge ? diff[COUNT_W-1:0] : trial[COUNT_W-1:0];
               if (step == STEP_W'(TOTAL_W - 1)) begin
                  quotient <= dvd_next;
                  valid    <= 1'b1;
                  state    <= DV_IDLE;
               end else begin
                  step <= step + STEP_W'(1);
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rtcc_wrap_watch.sv
`timescale 1ns/1ps
module rtcc_wrap_watch #(
   parameter int RT_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cnt_tick,
   input  logic            add_load,
   input  logic [RT_W-1:0] add_val,
   input  logic            in_isr,
   input  logic            chk_en,
   input  logic            ovf_clr,
   output logic [RT_W-1:0] value,
   output logic            overrun
);
   logic            step;
   logic [RT_W:0]   sum;
   logic            wrap;

   assign step = add_load | cnt_tick;
   assign sum  = {1'b0, value} + (add_load ? {1'b0, add_val} : (RT_W+1)'(1));
   assign wrap = step & sum[RT_W];

   always_ff @(posedge clk) begin
      if (rst) begin
         value   <= '0;
         overrun <= 1'b0;
      end else begin
         if (step) value <= sum[RT_W-1:0];
         if (wrap && in_isr && chk_en) overrun <= 1'b1;
         else if (ovf_clr)             overrun <= 1'b0;
      end
   end
endmodule

// File: rtl/isr_profiler.sv
`timescale 1ns/1ps
module isr_profiler #(
   parameter int CYC_W   = 16,
   parameter int TOTAL_W = 32,
   parameter int COUNT_W = 16,
   parameter int RTCC_W  = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               isr_enter,
   input  logic               isr_return,
   input  logic               retiw,
   input  logic [RTCC_W-1:0]  w_value,
   input  logic               cycle_tick,
   input  logic               rtcc_tick,
   input  logic               ovf_chk_en,
   input  logic               ovf_clear,
   output logic [CYC_W-1:0]   cyc_min,
   output logic [CYC_W-1:0]   cyc_max,
   output logic [TOTAL_W-1:0] cyc_total,
   output logic [COUNT_W-1:0] isr_count,
   output logic [TOTAL_W-1:0] avg_cycles,
   output logic               avg_valid,
   output logic [RTCC_W-1:0]  rtcc_value,
   output logic               overrun
);
   generate
      if (CYC_W < 1) begin : g_bad_cyc
         $error("CYC_W must be at least 1");
      end
      if (TOTAL_W < 2 || TOTAL_W < CYC_W) begin : g_bad_tot
         $error("TOTAL_W must be at least 2 and not narrower than CYC_W");
      end
      if (COUNT_W < 1) begin : g_bad_cnt
         $error("COUNT_W must be at least 1");
      end
      if (RTCC_W < 1) begin : g_bad_rt
         $error("RTCC_W must be at least 1");
      end
   endgenerate

   logic             in_isr;
   logic             ret_take;
   logic             span_done;
   logic [CYC_W-1:0] span_dur;

   isr_span_meter #(.CYC_W(CYC_W)) u_meter (
      .clk        (clk),
      .rst        (rst),
      .isr_enter  (isr_enter),
      .isr_return (isr_return),
      .cycle_tick (cycle_tick),
      .in_isr     (in_isr),
      .ret_take   (ret_take),
      .done       (span_done),
      .dur        (span_dur)
   );

   isr_stat_accum #(.CYC_W(CYC_W), .TOTAL_W(TOTAL_W), .COUNT_W(COUNT_W)) u_stats (
      .clk   (clk),
      .rst   (rst),
      .done  (span_done),
      .dur   (span_dur),
      .min_q (cyc_min),
      .max_q (cyc_max),
      .tot_q (cyc_total),
      .cnt_q (isr_count)
   );

   isr_avg_div #(.TOTAL_W(TOTAL_W), .COUNT_W(COUNT_W)) u_div (
      .clk      (clk),
      .rst      (rst),
      .start    (span_done),
      .dividend (cyc_total),
      .divisor  (isr_count),
      .quotient (avg_cycles),
      .valid    (avg_valid)
   );

   rtcc_wrap_watch #(.RT_W(RTCC_W)) u_rtcc (
      .clk      (clk),
      .rst      (rst),
      .cnt_tick (rtcc_tick),
      .add_load (ret_take & retiw),
      .add_val  (w_value),
      .in_isr   (in_isr),
      .chk_en   (ovf_chk_en),
      .ovf_clr  (ovf_clear),
      .value    (rtcc_value),
      .overrun  (overrun)
   );
endmodule

// File: rtl/isr_profiler_chk.sv
`timescale 1ns/1ps
module isr_profiler_chk #(
   parameter int CYC_W   = 16,
   parameter int TOTAL_W = 32,
   parameter int COUNT_W = 16,
   parameter int RTCC_W  = 8
) (
   input logic               clk,
   input logic               rst,
   input logic               isr_return,
   input logic               rtcc_tick,
   input logic               ovf_chk_en,
   input logic               ovf_clear,
   input logic [CYC_W-1:0]   cyc_min,
   input logic [CYC_W-1:0]   cyc_max,
   input logic [COUNT_W-1:0] isr_count,
   input logic               avg_valid,
   input logic [RTCC_W-1:0]  rtcc_value,
   input logic               overrun
);
   localparam logic [RTCC_W-1:0] RT_TOP = '1;

   a_r4_max_never_drops: assert property (@(posedge clk) disable iff (rst)
      (cyc_max != '0) |=> (cyc_max >= $past(cyc_max)));

   a_r4_min_not_above_max: assert property (@(posedge clk) disable iff (rst)
      (isr_count != '0) |-> (cyc_min <= cyc_max));

   a_r5_count_no_wrap: assert property (@(posedge clk) disable iff (rst)
      (isr_count != '0) |=> (isr_count != '0));

   a_r6_valid_needs_calls: assert property (@(posedge clk) disable iff (rst)
      $rose(avg_valid) |-> (isr_count != '0));

   a_r7_tick_wraps: assert property (@(posedge clk) disable iff (rst)
      (rtcc_tick && !isr_return && rtcc_value == RT_TOP) |=> (rtcc_value == '0));

   a_r9_disabled_holds_low: assert property (@(posedge clk) disable iff (rst)
      (!ovf_chk_en && !overrun) |=> !overrun);

   a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      (overrun && !ovf_clear) |=> overrun);
endmodule

bind isr_profiler isr_profiler_chk #(
   .CYC_W(CYC_W), .TOTAL_W(TOTAL_W), .COUNT_W(COUNT_W), .RTCC_W(RTCC_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .isr_return (isr_return),
   .rtcc_tick  (rtcc_tick),
   .ovf_chk_en (ovf_chk_en),
   .ovf_clear  (ovf_clear),
   .cyc_min    (cyc_min),
   .cyc_max    (cyc_max),
   .isr_count  (isr_count),
   .avg_valid  (avg_valid),
   .rtcc_value (rtcc_value),
   .overrun    (overrun)
);

// File: tb/isr_profiler_test.sv
`timescale 1ns/1ps
module isr_profiler_test;
   localparam int CW = 8;
   localparam int TW = 12;
   localparam int NW = 4;
   localparam int RW = 8;
   localparam int CMAX = (1 << CW) - 1;
   localparam int TMAX = (1 << TW) - 1;
   localparam int NMAX = (1 << NW) - 1;

   // length, exp min, exp max, exp total, exp count, exp avg
   localparam int VEC [4][6] = '{
      '{ 5,  5,  5,  5, 1,  5},
      '{12,  5, 12, 17, 2,  8},
      '{ 3,  3, 12, 20, 3,  6},
      '{20,  3, 20, 40, 4, 10}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          isr_enter = 1'b0, isr_return = 1'b0, retiw = 1'b0;
   logic [RW-1:0] w_value = '0;
   logic          cycle_tick = 1'b0, rtcc_tick = 1'b0;
   logic          ovf_chk_en = 1'b0, ovf_clear = 1'b0;
   logic [CW-1:0] cyc_min, cyc_max;
   logic [TW-1:0] cyc_total, avg_cycles;
   logic [NW-1:0] isr_count;
   logic          avg_valid;
   logic [RW-1:0] rtcc_value;
   logic          overrun;

   isr_profiler #(.CYC_W(CW), .TOTAL_W(TW), .COUNT_W(NW), .RTCC_W(RW)) uut (
      .clk(clk), .rst(rst), .isr_enter(isr_enter), .isr_return(isr_return),
      .retiw(retiw), .w_value(w_value), .cycle_tick(cycle_tick),
      .rtcc_tick(rtcc_tick), .ovf_chk_en(ovf_chk_en), .ovf_clear(ovf_clear),
      .cyc_min(cyc_min), .cyc_max(cyc_max), .cyc_total(cyc_total),
      .isr_count(isr_count), .avg_cycles(avg_cycles), .avg_valid(avg_valid),
      .rtcc_value(rtcc_value), .overrun(overrun)
   );

   always #2.5 clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference model state
   bit m_act = 0;
   int m_dur = 0;
   int m_min = CMAX, m_max = 0, m_tot = 0, m_cnt = 0;
   int m_rt = 0;
   bit m_ov = 0;

   task automatic check(string tag, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      check({tag, " R4 min"}, cyc_min, m_min);
      check({tag, " R4 max"}, cyc_max, m_max);
      check({tag, " R5 total"}, cyc_total, m_tot);
      check({tag, " R5 count"}, isr_count, m_cnt);
      check({tag, " R7 rtcc"}, rtcc_value, m_rt);
      check({tag, " R10 overrun"}, overrun, m_ov);
      if (m_cnt > 0) begin
         check({tag, " R6 avg_valid"}, avg_valid, 1);
         check({tag, " R6 avg"}, avg_cycles, m_tot / m_cnt);
      end
   endtask

   function automatic void finish_isr(int d);
      if (d < m_min) m_min = d;
      if (d > m_max) m_max = d;
      m_tot = (m_tot + d > TMAX) ? TMAX : m_tot + d;
      if (m_cnt < NMAX) m_cnt++;
   endfunction

   // one clock cycle of stimulus, entered and left at a falling edge
   task automatic step(bit en, bit ret, bit rw, int w, bit ct, bit rt, bit clr);
      bit was_act;
      bit wrap;
      isr_enter  = en;
      isr_return = ret;
      retiw      = rw;
      w_value    = RW'(w);
      cycle_tick = ct;
      rtcc_tick  = rt;
      ovf_clear  = clr;
      was_act = m_act;
      wrap = 0;
      if (!was_act) begin
         if (en) begin
            m_act = 1;
            m_dur = ct;
         end
      end else begin
         if (ct && m_dur < CMAX) m_dur++;
         if (ret) begin
            m_act = 0;
            finish_isr(m_dur);
         end
      end
      if (was_act && ret && rw) begin
         wrap = (m_rt + w) > 255;
         m_rt = (m_rt + w) % 256;
      end else if (rt) begin
         wrap = (m_rt == 255);
         m_rt = (m_rt + 1) % 256;
      end
      if (wrap && was_act && ovf_chk_en) m_ov = 1;
      else if (clr) m_ov = 0;
      @(negedge clk);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic ticks_out(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, 0);
   endtask

   task automatic run_isr(int len);
      step(1, 0, 0, 0, 1, 0, 0);
      for (int i = 0; i < len - 2; i++) step(0, 0, 0, 0, 1, 0, 0);
      step(0, 1, 0, 0, 1, 0, 0);
      idle(TW + 6);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      check("R1 min", cyc_min, CMAX);
      check("R1 max", cyc_max, 0);
      check("R1 total", cyc_total, 0);
      check("R1 count", isr_count, 0);
      check("R1 avg_valid", avg_valid, 0);
      check("R1 rtcc", rtcc_value, 0);
      check("R1 overrun", overrun, 0);

      // table of routine lengths with expected statistics (R2 R4 R5 R6)
      for (int i = 0; i < 4; i++) begin
         run_isr(VEC[i][0]);
         check("R4 table min", cyc_min, VEC[i][1]);
         check("R4 table max", cyc_max, VEC[i][2]);
         check("R5 table total", cyc_total, VEC[i][3]);
         check("R5 table count", isr_count, VEC[i][4]);
         check("R6 table avg", avg_cycles, VEC[i][5]);
         check("R6 table avg_valid", avg_valid, 1);
      end

      // R3 nested entry ignored, duration 10 from first entry
      step(1, 0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0, 0);
      step(1, 0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 0);
      step(0, 1, 0, 0, 1, 0, 0);
      idle(1);
      check("R6 avg_valid drops with update", avg_valid, 0);
      check("R5 count updated", isr_count, 5);
      idle(TW + 6);
      check("R3 nested total", cyc_total, 50);
      check_all("R3 nested");

      // R3 stray return ignored
      step(0, 1, 0, 0, 1, 0, 0);
      idle(TW + 6);
      check_all("R3 stray return");

      // R2 only ticked cycles count: duration 2
      step(1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 0, 0);
      step(0, 1, 0, 0, 1, 0, 0);
      idle(TW + 6);
      check("R2 gated min", cyc_min, 2);
      check_all("R2 gated");

      // R2 duration saturation
      run_isr(300);
      check("R2 saturated max", cyc_max, CMAX);
      check_all("R2 saturate");

      // R7 R9 immediate wrap inside a routine
      ovf_chk_en = 1'b1;
      ticks_out(250);
      check_all("R7 preload");
      step(1, 0, 0, 0, 1, 0, 0);
      for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 1, 0);
      check("R7 rtcc at top", rtcc_value, 255);
      check("R9 not yet", overrun, 0);
      step(0, 0, 0, 0, 1, 1, 0);
      check("R7 rtcc wrapped", rtcc_value, 0);
      check("R9 flag at wrap edge", overrun, 1);
      step(0, 1, 0, 0, 1, 0, 0);
      idle(TW + 6);
      check_all("R10 sticky after return");
      step(0, 0, 0, 0, 0, 0, 1);
      check("R10 cleared", overrun, 0);

      // R8 add-W return, check disabled
      ticks_out(216);
      ovf_chk_en = 1'b0;
      step(1, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0);
      step(0, 1, 1, 8'h52, 1, 0, 0);
      check("R8 add wraps mod 256", rtcc_value, 8'h2A);
      check("R9 disabled no flag", overrun, 0);
      idle(TW + 6);
      ovf_chk_en = 1'b1;

      // R9 add-W wrap with check enabled
      step(1, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0);
      step(0, 1, 1, 8'hE0, 1, 0, 0);
      check("R8 add result", rtcc_value, 8'h0A);
      check("R9 add wrap flags", overrun, 1);
      idle(TW + 6);
      step(0, 0, 0, 0, 0, 0, 1);

      // R8 tick ignored during add-W return
      step(1, 0, 0, 0, 1, 0, 0);
      step(0, 1, 1, 5, 1, 1, 0);
      check("R8 tick ignored", rtcc_value, 8'h0F);
      check("R9 no wrap no flag", overrun, 0);
      idle(TW + 6);
      check_all("R8 after add");

      // R10 set beats clear
      ticks_out(240);
      check("R9 no wrap outside", overrun, 0);
      step(1, 0, 0, 0, 1, 0, 0);
      step(0, 0, 0, 0, 1, 1, 1);
      check("R10 set wins over clear", overrun, 1);
      step(0, 1, 0, 0, 1, 0, 0);
      idle(TW + 6);
      step(0, 0, 0, 0, 0, 0, 1);

      // R9 wrap outside a routine does not flag
      ticks_out(256);
      check("R9 outside wrap rtcc", rtcc_value, 0);
      check("R9 outside wrap flag", overrun, 0);

      // R5 saturation of total and count
      for (int i = 0; i < 17; i++) run_isr(300);
      check("R5 total saturated", cyc_total, TMAX);
      check("R5 count saturated", isr_count, NMAX);
      check_all("R5 saturate");

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule